// File: doc/BRIEF.md
# Oversampling Asynchronous Frame Receiver

This block recovers characters from an asynchronous NRZ serial line. It samples the line once per pulse of a sampling tick that runs at sixteen times the bit rate. A falling edge on the idle line opens a frame. Each bit is decided by a majority vote over three samples taken around the middle of the bit period. The data byte arrives least significant bit first. A mode input selects a 10-bit frame (start, eight data, stop) or an 11-bit frame (start, eight data, ninth bit, stop).

While the data and ninth bits are being received, every line transition that falls away from the expected bit boundary realigns the sixteen-phase counter. A transmitter whose bit period differs from the nominal one is therefore tracked across the frame. At the end of the frame, the byte, the ninth bit and a framing-error flag are presented together with a one-cycle valid pulse. A low stop bit raises the framing-error flag, and the byte is still delivered.

Top module: `sci_frame_rx`

## Requirements
- R1: After reset, rx_valid, rx_ferr, rx_byte and rx_bit9 are all 0. A frame starts only on a high-to-low transition of the synchronised line, seen on a tick while the receiver is idle.
- R2: If the vote over samples 7, 8 and 9 of the start bit reads high, the receiver returns to idle without producing a valid pulse. Samples are numbered 0 to 15 from the tick that first saw the falling edge.
- R3: Each bit value is the majority of its samples 7, 8 and 9, so a one-tick glitch on sample 8 does not change the received value.
- R4: The first data bit after the start bit is stored in bit 0 of rx_byte, and the eighth is stored in bit 7.
- R5: When the mode latched at the start bit is 1, the bit after the eighth data bit appears on rx_bit9 and the next bit is treated as the stop bit. In 10-bit mode rx_bit9 reads 0.
- R6: A stop bit voted low sets rx_ferr to 1 and a stop bit voted high sets it to 0. Both cases still deliver the byte, and rx_ferr holds its value until the next valid pulse.
- R7: rx_valid is a single-cycle pulse, asserted in the clock cycle after the tick on which the stop bit is voted. rx_byte, rx_bit9 and rx_ferr change only in the cycle that carries that pulse.
- R8: During data and ninth bits, an edge at sample 1 to 6 restarts the current bit at sample 0. An edge at sample 10 to 15 ends the current bit and starts the next one at sample 0. As a result, frames of alternating bits with 15-tick or 17-tick bit periods are received correctly.
- R9: After a framing error with the line held low, no new frame starts until the line has returned high and fallen again.
- R10: The mode input is sampled when the start edge is accepted. A change of the mode input later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Sampling enable, one pulse per 1/16 bit period |
| frame11 | input | 1 | 1 selects 11-bit frames, 0 selects 10-bit frames |
| rx_byte | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit (0 in 10-bit mode) |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_ferr | output | 1 | Stop bit of the last frame was low |

## Verification
Random bytes in both frame lengths at the nominal bit period show that the bit order, the ninth-bit placement and the stop-bit position are correct. Alternating-bit frames at 15-tick and 17-tick bit periods show that the phase realignment is working, since a receiver with a free-running phase drifts out of the bit by the end of such a frame. A short low pulse, a mid-bit glitch, a low stop bit followed by a held-low line, and a mode flip during a frame separate false-start rejection, majority voting, framing-error reporting, break handling and mode latching from one another.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_NINTH = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/sci_rx_sync.sv
module sci_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/sci_rx_sampler.sv
module sci_rx_sampler #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_s,
  input  logic hunt,
  input  logic resync_en,
  output logic start_stb,
  output logic vote_stb,
  output logic vote_bit,
  output logic bit_end
);
  import sci_rx_pkg::*;

  localparam int unsigned PH_W      = $clog2(OSR);
  localparam int unsigned MID       = OSR / 2;
  localparam int unsigned V_LO      = MID - 1;
  localparam int unsigned V_HI      = MID + 1;
  localparam int unsigned LATE_MAX  = MID - 2;
  localparam int unsigned EARLY_MIN = MID + 2;
  localparam int unsigned LAST      = OSR - 1;

  logic            prev_q, prev_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            s_lo_q, s_lo_d;
  logic            s_mid_q, s_mid_d;

  logic line_edge, line_fall, late_edge, early_edge, at_last;

  always_comb begin
    line_edge  = line_s ^ prev_q;
    line_fall  = prev_q & ~line_s;
    at_last    = (cnt_q == PH_W'(LAST));
    late_edge  = resync_en & line_edge &
                 (cnt_q >= PH_W'(1)) & (cnt_q <= PH_W'(LATE_MAX));
    early_edge = resync_en & line_edge & (cnt_q >= PH_W'(EARLY_MIN));

    start_stb = tick & hunt & line_fall;
    vote_stb  = tick & ~hunt & (cnt_q == PH_W'(V_HI));
    vote_bit  = maj3(s_lo_q, s_mid_q, line_s);
    bit_end   = tick & ~hunt & (at_last | early_edge);
  end

  always_comb begin
    prev_d  = prev_q;
    cnt_d   = cnt_q;
    s_lo_d  = s_lo_q;
    s_mid_d = s_mid_q;
    if (tick) begin
      prev_d = line_s;
      if (hunt) begin
        cnt_d = line_fall ? PH_W'(1) : '0;
      end else if (late_edge || early_edge) begin
        cnt_d = PH_W'(1);
      end else if (at_last) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + PH_W'(1);
      end
      if (cnt_q == PH_W'(V_LO)) s_lo_d  = line_s;
      if (cnt_q == PH_W'(MID))  s_mid_d = line_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      cnt_q   <= '0;
      s_lo_q  <= 1'b1;
      s_mid_q <= 1'b1;
    end else begin
      prev_q  <= prev_d;
      cnt_q   <= cnt_d;
      s_lo_q  <= s_lo_d;
      s_mid_q <= s_mid_d;
    end
  end

endmodule

// File: rtl/sci_rx_ctrl.sv
module sci_rx_ctrl #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_stb,
  input  logic                 vote_stb,
  input  logic                 vote_bit,
  input  logic                 bit_end,
  input  logic                 mode_in,
  output logic                 hunt,
  output logic                 resync_en,
  output logic                 mode_lat,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_bit9,
  output logic                 rx_valid,
  output logic                 rx_ferr
);
  import sci_rx_pkg::*;

  localparam int unsigned BC_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int unsigned BC_LAST = DATA_BITS - 1;

  rx_state_t              state_q, state_d;
  logic [BC_W-1:0]        bcnt_q, bcnt_d;
  logic [DATA_BITS-1:0]   shift_q, shift_d;
  logic                   mode_q, mode_d;
  logic                   ninth_q, ninth_d;
  logic [DATA_BITS-1:0]   byte_q, byte_d;
  logic                   b9_q, b9_d;
  logic                   valid_q, valid_d;
  logic                   ferr_q, ferr_d;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    shift_d = shift_q;
    mode_d  = mode_q;
    ninth_d = ninth_q;
    byte_d  = byte_q;
    b9_d    = b9_q;
    valid_d = 1'b0;
    ferr_d  = ferr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_stb) begin
          state_d = ST_START;
          mode_d  = mode_in;
        end
      end
      ST_START: begin
        if (vote_stb && vote_bit) begin
          state_d = ST_IDLE;
        end else if (bit_end) begin
          state_d = ST_DATA;
          bcnt_d  = '0;
        end
      end
      ST_DATA: begin
        if (vote_stb) shift_d = {vote_bit, shift_q[DATA_BITS-1:1]};
        if (bit_end) begin
          if (bcnt_q == BC_W'(BC_LAST)) state_d = mode_q ? ST_NINTH : ST_STOP;
          else                          bcnt_d  = bcnt_q + BC_W'(1);
        end
      end
      ST_NINTH: begin
        if (vote_stb) ninth_d = vote_bit;
        if (bit_end)  state_d = ST_STOP;
      end
      ST_STOP: begin
        if (vote_stb) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
          byte_d  = shift_q;
          b9_d    = mode_q & ninth_q;
          ferr_d  = ~vote_bit;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      shift_q <= '0;
      mode_q  <= 1'b0;
      ninth_q <= 1'b0;
      byte_q  <= '0;
      b9_q    <= 1'b0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      shift_q <= shift_d;
      mode_q  <= mode_d;
      ninth_q <= ninth_d;
      byte_q  <= byte_d;
      b9_q    <= b9_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign hunt      = (state_q == ST_IDLE);
  assign resync_en = (state_q == ST_DATA) || (state_q == ST_NINTH);
  assign mode_lat  = mode_q;
  assign rx_byte   = byte_q;
  assign rx_bit9   = b9_q;
  assign rx_valid  = valid_q;
  assign rx_ferr   = ferr_q;

endmodule

// File: rtl/sci_frame_rx.sv
module sci_frame_rx #(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic                 os_tick,
  input  logic                 frame11,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_bit9,
  output logic                 rx_valid,
  output logic                 rx_ferr
);

  logic line_s;
  logic hunt, resync_en, mode_lat;
  logic start_stb, vote_stb, vote_bit, bit_end;

  sci_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  sci_rx_sampler #(.OSR(OSR)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .line_s   (line_s),
    .hunt     (hunt),
    .resync_en(resync_en),
    .start_stb(start_stb),
    .vote_stb (vote_stb),
    .vote_bit (vote_bit),
    .bit_end  (bit_end)
  );

  sci_rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_stb(start_stb),
    .vote_stb (vote_stb),
    .vote_bit (vote_bit),
    .bit_end  (bit_end),
    .mode_in  (frame11),
    .hunt     (hunt),
    .resync_en(resync_en),
    .mode_lat (mode_lat),
    .rx_byte  (rx_byte),
    .rx_bit9  (rx_bit9),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_ferr)
  );

endmodule

// File: rtl/sci_frame_rx_chk.sv
module sci_frame_rx_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 os_tick,
  input logic                 mode_lat,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_bit9,
  input logic                 rx_valid,
  input logic                 rx_ferr
);

  // R7: valid lasts one cycle only
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7: valid follows a sampling tick
  a_r7_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(os_tick));

  // R5: ninth bit reads 0 for frames latched in 10-bit mode
  a_r5_bit9_zero_short: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode_lat) |-> !rx_bit9);

  // R6: framing flag moves only with a completed frame
  a_r6_ferr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_ferr) |-> rx_valid);

  // R7: byte and ninth bit are held between frames
  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_byte) && $stable(rx_bit9)));

endmodule

bind sci_frame_rx sci_frame_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .os_tick (os_tick),
  .mode_lat(mode_lat),
  .rx_byte (rx_byte),
  .rx_bit9 (rx_bit9),
  .rx_valid(rx_valid),
  .rx_ferr (rx_ferr)
);

// File: tb/test_sci_frame_rx.sv
module test_sci_frame_rx;

  logic       clk;
  logic       rst_n;
  logic       rx_line;
  logic       os_tick;
  logic       frame11;
  logic [7:0] rx_byte;
  logic       rx_bit9;
  logic       rx_valid;
  logic       rx_ferr;

  int checks = 0;
  int errors = 0;
  int nvalid = 0;
  int hi_run = 0;
  int cycles = 0;
  logic [7:0] cap_byte = '0;
  logic       cap_b9 = 1'b0;
  logic       cap_ferr = 1'b0;
  logic [1:0] tdiv = '0;

  sci_frame_rx i_sci_frame_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_line (rx_line),
    .os_tick (os_tick),
    .frame11 (frame11),
    .rx_byte (rx_byte),
    .rx_bit9 (rx_bit9),
    .rx_valid(rx_valid),
    .rx_ferr (rx_ferr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // tick every fourth cycle, changed away from the active edge
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  // output monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      nvalid   = nvalid + 1;
      cap_byte = rx_byte;
      cap_b9   = rx_bit9;
      cap_ferr = rx_ferr;
      hi_run   = hi_run + 1;
      if (hi_run > 1) begin
        errors = errors + 1;
        $display("FAIL R7 valid width actual %0d expected 1", hi_run);
      end
    end else begin
      hi_run = 0;
    end
  end

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
      summary_and_end();
    end
  end

  function automatic logic exp_b9(input logic m, input logic b9);
    return m & b9;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!os_tick) @(posedge clk);
  endtask

  task automatic drive_for(input logic v, input int n);
    @(negedge clk);
    rx_line = v;
    for (int k = 0; k < n; k++) wait_tick();
  endtask

  // sends one frame; glitch_bit is the frame bit index flipped at sample 8
  task automatic send_frame(input logic [7:0] d, input logic m, input logic b9,
                            input logic stop_v, input int per, input int glitch_bit,
                            input logic flip_mode);
    logic [10:0] bits;
    int nb;
    nb = m ? 11 : 10;
    bits = '0;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    if (m) begin
      bits[9]  = b9;
      bits[10] = stop_v;
    end else begin
      bits[9] = stop_v;
    end
    frame11 = m;
    for (int i = 0; i < nb; i++) begin
      for (int j = 0; j < per; j++) begin
        @(negedge clk);
        rx_line = (i == glitch_bit && j == 8) ? ~bits[i] : bits[i];
        wait_tick();
      end
      if (i == 0 && flip_mode) begin
        @(negedge clk);
        frame11 = ~m;
      end
    end
  endtask

  task automatic expect_frame(input string req, input int n0, input logic [7:0] d,
                              input logic m, input logic b9, input logic ferr);
    chk({req, " valid count"}, nvalid, n0 + 1);
    chk({req, " byte"}, cap_byte, d);
    chk({req, " ninth"}, cap_b9, exp_b9(m, b9));
    chk({req, " ferr"}, cap_ferr, ferr);
  endtask

  initial begin
    int n0;
    logic [7:0] d;
    logic m, b9;
    rst_n = 1'b0;
    rx_line = 1'b1;
    frame11 = 1'b0;
    void'($urandom(32'h5C1_0B0E));
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", rx_valid, 0);
    chk("R1 reset ferr", rx_ferr, 0);
    chk("R1 reset byte", rx_byte, 0);
    chk("R1 reset bit9", rx_bit9, 0);
    rst_n = 1'b1;
    drive_for(1'b1, 20);

    // R4: LSB-first ordering, 10-bit frame
    n0 = nvalid;
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 16, -1, 1'b0);
    drive_for(1'b1, 6);
    expect_frame("R4 byte 0xA5", n0, 8'hA5, 1'b0, 1'b0, 1'b0);
    n0 = nvalid;
    send_frame(8'h01, 1'b0, 1'b1, 1'b1, 16, -1, 1'b0);
    drive_for(1'b1, 6);
    expect_frame("R4 lsb only", n0, 8'h01, 1'b0, 1'b0, 1'b0);

    // R5: 11-bit frames with both ninth-bit values
    n0 = nvalid;
    send_frame(8'h3C, 1'b1, 1'b1, 1'b1, 16, -1, 1'b0);
    drive_for(1'b1, 6);
    expect_frame("R5 ninth=1", n0, 8'h3C, 1'b1, 1'b1, 1'b0);
    n0 = nvalid;
    send_frame(8'h80, 1'b1, 1'b0, 1'b1, 16, -1, 1'b0);
    drive_for(1'b1, 6);
    expect_frame("R5 ninth=0", n0, 8'h80, 1'b1, 1'b0, 1'b0);

    // R3: one-tick glitch on sample 8 of data bit 3
    n0 = nvalid;
    send_frame(8'hF0, 1'b0, 1'b0, 1'b1, 16, 4, 1'b0);
    drive_for(1'b1, 6);
    expect_frame("R3 glitch", n0, 8'hF0, 1'b0, 1'b0, 1'b0);

    // R2: short low pulse is a false start
    n0 = nvalid;
    drive_for(1'b0, 5);
    drive_for(1'b1, 200);
    chk("R2 no valid after false start", nvalid, n0);
    n0 = nvalid;
    send_frame(8'h81, 1'b0, 1'b0, 1'b1, 16, -1, 1'b0);
    drive_for(1'b1, 6);
    expect_frame("R2 frame after false start", n0, 8'h81, 1'b0, 1'b0, 1'b0);

    // R6: low stop bit, byte still delivered
    n0 = nvalid;
    send_frame(8'h5A, 1'b1, 1'b1, 1'b0, 16, -1, 1'b0);
    // R9: line held low after the framing error
    drive_for(1'b0, 60);
    expect_frame("R6 framing error", n0, 8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R9 no frame while held low", nvalid, n0 + 1);
    drive_for(1'b1, 20);
    chk("R6 ferr held", rx_ferr, 1);
    n0 = nvalid;
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 16, -1, 1'b0);
    drive_for(1'b1, 6);
    expect_frame("R6 ferr cleared", n0, 8'hC3, 1'b0, 1'b0, 1'b0);

    // R8: skewed bit periods with alternating bits
    n0 = nvalid;
    send_frame(8'h55, 1'b0, 1'b0, 1'b1, 15, -1, 1'b0);
    drive_for(1'b1, 10);
    expect_frame("R8 period 15", n0, 8'h55, 1'b0, 1'b0, 1'b0);
    n0 = nvalid;
    send_frame(8'h55, 1'b0, 1'b0, 1'b1, 17, -1, 1'b0);
    drive_for(1'b1, 10);
    expect_frame("R8 period 17", n0, 8'h55, 1'b0, 1'b0, 1'b0);

    // R10: mode flip after the start bit does not alter the frame
    n0 = nvalid;
    send_frame(8'h6E, 1'b0, 1'b0, 1'b1, 16, -1, 1'b1);
    drive_for(1'b1, 6);
    expect_frame("R10 mode latched 10-bit", n0, 8'h6E, 1'b0, 1'b0, 1'b0);
    n0 = nvalid;
    send_frame(8'h92, 1'b1, 1'b1, 1'b1, 16, -1, 1'b1);
    drive_for(1'b1, 6);
    expect_frame("R10 mode latched 11-bit", n0, 8'h92, 1'b1, 1'b1, 1'b0);

    // R4 R5: random frames at the nominal period
    for (int r = 0; r < 40; r++) begin
      d  = 8'($urandom);
      m  = 1'($urandom);
      b9 = 1'($urandom);
      n0 = nvalid;
      send_frame(d, m, b9, 1'b1, 16, -1, 1'b0);
      drive_for(1'b1, 2 + int'($urandom % 8));
      expect_frame("R4 R5 random", n0, d, m, b9, 1'b0);
    end

    summary_and_end();
  end

endmodule